// File: doc/BRIEF.md
# SMBus Configuration Register Slave

This block is a two-wire bus slave, compatible with SMBus and I2C timing, that gives a host read and write access to a bank of eight 8-bit configuration registers. The block samples SCL and SDA with the system clock. Each line passes through a synchroniser and a glitch filter. The filtered levels produce start, stop and edge strobes, and a protocol engine acts on those strobes. The engine answers only at the 7-bit device address 69h, which appears on the wire as D2h for a write and D3h for a read. It drives SDA only through an open-drain enable.

The first byte after a write address is a command byte:

- Bit 7 selects the access type: 1 means a single-register access and 0 means a block transfer.
- Bits 6:5 must be zero.
- Bits 4:0 carry the register offset for a single-register access.

A block write carries a byte count and then the data, starting at offset 0. A block read is issued through a repeated start. It returns the count (always 8) and then the registers from offset 0 upward. The register contents are presented in parallel on `cfg_q`, where they control the rest of the chip.

Top module: `smb_cfg_slave`

## Requirements
- R1: After reset, the offsets 0 to 7 hold 7Ch, 00h, EBh, AFh, 01h, 00h, 13h and 38h. Offset n appears on `cfg_q[8n+7:8n]`, and SDA is released.
- R2: The slave acknowledges the address byte D2h (write) and D3h (read). Any other address byte is not acknowledged. After such a byte the slave drives nothing and changes nothing until the next start condition.
- R3: A command byte with bits 6:5 not equal to 00 is not acknowledged, and neither is a block command (bit 7 = 0) with bits 4:0 not equal to 00000. The rest of that transaction is ignored.
- R4: A single-register write (command bit 7 = 1) stores its data byte at offset bits 4:0 and acknowledges it. A further data byte in the same transaction is not acknowledged and is discarded.
- R5: A block write acknowledges the count byte and up to that many data bytes. It stores them from offset 0 upward. Bytes that fall past offset 7 are acknowledged and dropped. Bytes beyond the count are not acknowledged.
- R6: Offset 7 is read-only. A write to it is acknowledged, and the register keeps 38h.
- R7: After a repeated start with D3h, a single-register read returns the register at the commanded offset. An offset of 8 or more returns 00h.
- R8: A block read returns 08h, then offsets 0 to 7, then 00h for as long as the master keeps acknowledging. A master NACK ends the data.
- R9: Every byte is sent most significant bit first. The slave changes its SDA enable only while SCL is low.
- R10: A stop after any complete byte ends the transaction. Bytes already accepted stay written, and the next start begins a new transaction.
- R11: A pulse on SDA or SCL that lasts fewer than FILT_LEN clock cycles after the synchroniser has no effect on the protocol.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock; it must run at least about 16 times faster than SCL |
| rst_n | input | 1 | Asynchronous active-low reset |
| scl_i | input | 1 | SCL level as seen on the bus |
| sda_i | input | 1 | SDA level as seen on the bus (wired-AND of all drivers) |
| sda_oe | output | 1 | 1 pulls SDA low; 0 releases it |
| cfg_q | output | NREG*8 | Parallel view of all registers, offset n in bits 8n+7:8n |

## Verification
A corrupted protocol state shows up at the ninth clock of the next byte. There the acknowledge bit is wrong: it is missing where R2 to R5 expect it, or present where they forbid it. A wrong transmit shift or pointer appears as a wrong data byte in a read, in the same byte. A misdirected register write appears on `cfg_q` within a few system clocks of the eighth SCL rising edge, and a later bus read confirms the value. Filter or edge-detect faults show up as phantom start conditions that reset the byte framing, and therefore as lost acknowledges.

// File: rtl/smb_cfg_pkg.sv
package smb_cfg_pkg;

   // Width of the offset field carried in the command byte.
   localparam int PTR_W = 5;

   // Power-up contents, offset 0 in the lowest byte.
   localparam logic [63:0] CFG_INIT = 64'h3813_0001_AFEB_007C;

   typedef enum logic [3:0] {
      S_IDLE,
      S_ADDR,
      S_CMD,
      S_CNT,
      S_WDATA,
      S_ACK,
      S_RDATA,
      S_RACK,
      S_IGNORE
   } smb_state_e;

endpackage

// File: rtl/smb_in_filter.sv
module smb_in_filter #(
   parameter int SYNC_STAGES = 2,
   parameter int FILT_LEN    = 3
) (
   input  logic clk,
   input  logic rst_n,
   input  logic din,
   output logic dout
);
   localparam int CNT_W = (FILT_LEN > 1) ? $clog2(FILT_LEN + 1) : 1;
   localparam logic [CNT_W-1:0] CNT_MAX = CNT_W'(FILT_LEN - 1);

   logic [SYNC_STAGES-1:0] sync;
   logic                   s;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) sync <= '1;
      else        sync <= {sync[SYNC_STAGES-2:0], din};
   end
   assign s = sync[SYNC_STAGES-1];

   generate
      if (FILT_LEN <= 1) begin : g_pass
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) dout <= 1'b1;
            else        dout <= s;
         end
      end else begin : g_count
         logic [CNT_W-1:0] cnt;
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) begin
               cnt  <= '0;
               dout <= 1'b1;
            end else if (s == dout) begin
               cnt <= '0;
            end else if (cnt == CNT_MAX) begin
               cnt  <= '0;
               dout <= s;
            end else begin
               cnt <= cnt + CNT_W'(1);
            end
         end
      end
   endgenerate

   // R11: the filtered level only ever moves to the synchronised value.
   p_filter_follows_r11: assert property (@(posedge clk) disable iff (!rst_n)
      !$stable(dout) |-> (dout == $past(s)));

endmodule

// File: rtl/smb_bus_events.sv
module smb_bus_events (
   input  logic clk,
   input  logic rst_n,
   input  logic scl,
   input  logic sda,
   output logic start_o,
   output logic stop_o,
   output logic rise_o,
   output logic fall_o
);
   logic scl_p, sda_p;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         scl_p <= 1'b1;
         sda_p <= 1'b1;
      end else begin
         scl_p <= scl;
         sda_p <= sda;
      end
   end

   assign start_o = scl & scl_p &  sda_p & ~sda;
   assign stop_o  = scl & scl_p & ~sda_p &  sda;
   assign rise_o  =  scl & ~scl_p;
   assign fall_o  = ~scl &  scl_p;

endmodule

// File: rtl/smb_reg_bank.sv
module smb_reg_bank #(
   parameter int                NREG    = 8,
   parameter logic [NREG*8-1:0] INIT    = '0,
   parameter logic [NREG-1:0]   RO_MASK = '0,
   localparam int               IDX_W   = (NREG > 1) ? $clog2(NREG) : 1
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              we,
   input  logic [IDX_W-1:0]  waddr,
   input  logic [7:0]        wdata,
   output logic [NREG*8-1:0] q
);
   logic [7:0] rv [NREG];

   generate
      for (genvar i = 0; i < NREG; i++) begin : g_reg
         if (RO_MASK[i]) begin : g_ro
            assign rv[i] = INIT[i*8 +: 8];
         end else begin : g_rw
            logic [7:0] r;
            always_ff @(posedge clk or negedge rst_n) begin
               if (!rst_n)                          r <= INIT[i*8 +: 8];
               else if (we && waddr == IDX_W'(i))   r <= wdata;
            end
            assign rv[i] = r;
         end
         assign q[i*8 +: 8] = rv[i];
      end
   endgenerate

   // R4: a write to a writable offset is visible on the next cycle.
   p_write_lands_r4: assert property (@(posedge clk) disable iff (!rst_n)
      (we && !RO_MASK[waddr]) |=> (rv[$past(waddr)] == $past(wdata)));

endmodule

// File: rtl/smb_cfg_slave.sv
module smb_cfg_slave
   import smb_cfg_pkg::*;
#(
   parameter int                NREG        = 8,
   parameter logic [6:0]        DEV_ADDR    = 7'h69,
   parameter int                SYNC_STAGES = 2,
   parameter int                FILT_LEN    = 3,
   parameter logic [NREG*8-1:0] INIT        = CFG_INIT,
   parameter logic [NREG-1:0]   RO_MASK     = {1'b1, {(NREG-1){1'b0}}}
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              scl_i,
   input  logic              sda_i,
   output logic              sda_oe,
   output logic [NREG*8-1:0] cfg_q
);
   localparam int                 IDX_W   = (NREG > 1) ? $clog2(NREG) : 1;
   localparam logic [PTR_W:0]     NREG_P  = (PTR_W+1)'(NREG);
   localparam logic [7:0]         BLK_CNT = 8'(NREG);
   localparam logic [PTR_W-1:0]   PTR_ONE = PTR_W'(1);

   generate
      if (NREG < 2 || NREG > 32) begin : g_bad_nreg
         $error("NREG must lie between 2 and 32");
      end
      if (SYNC_STAGES < 2) begin : g_bad_sync
         $error("SYNC_STAGES must be at least 2");
      end
      if (FILT_LEN < 1) begin : g_bad_filt
         $error("FILT_LEN must be at least 1");
      end
   endgenerate

   // Input conditioning and bus events
   logic scl_f, sda_f;
   logic ev_start, ev_stop, ev_rise, ev_fall;

   smb_in_filter #(.SYNC_STAGES(SYNC_STAGES), .FILT_LEN(FILT_LEN)) u_scl_filt (
      .clk(clk), .rst_n(rst_n), .din(scl_i), .dout(scl_f));
   smb_in_filter #(.SYNC_STAGES(SYNC_STAGES), .FILT_LEN(FILT_LEN)) u_sda_filt (
      .clk(clk), .rst_n(rst_n), .din(sda_i), .dout(sda_f));

   smb_bus_events u_evt (
      .clk(clk), .rst_n(rst_n), .scl(scl_f), .sda(sda_f),
      .start_o(ev_start), .stop_o(ev_stop), .rise_o(ev_rise), .fall_o(ev_fall));

   // Register bank
   logic              we;
   logic [IDX_W-1:0]  waddr;
   logic [7:0]        wdata;

   smb_reg_bank #(.NREG(NREG), .INIT(INIT), .RO_MASK(RO_MASK)) u_bank (
      .clk(clk), .rst_n(rst_n), .we(we), .waddr(waddr), .wdata(wdata), .q(cfg_q));

   logic [7:0] regv [NREG];
   generate
      for (genvar i = 0; i < NREG; i++) begin : g_view
         assign regv[i] = cfg_q[i*8 +: 8];
      end
   endgenerate

   // Protocol state
   smb_state_e       st, nxt;
   logic [3:0]       bcnt;
   logic [6:0]       sh;
   logic [7:0]       tx;
   logic             ack_lo;
   logic             more;
   logic             mode_byte;
   logic [PTR_W-1:0] off, wr_ptr, rd_ptr;
   logic [7:0]       wcnt;

   logic [7:0]       rx_byte;
   logic             off_in, wr_in, rd_in;
   logic [7:0]       off_val, rd_val;
   logic [PTR_W-1:0] off_step, wr_step, rd_step;

   assign rx_byte  = {sh, sda_f};
   assign off_in   = {1'b0, off}    < NREG_P;
   assign wr_in    = {1'b0, wr_ptr} < NREG_P;
   assign rd_in    = {1'b0, rd_ptr} < NREG_P;
   assign off_val  = off_in ? regv[off[IDX_W-1:0]]    : 8'h00;
   assign rd_val   = rd_in  ? regv[rd_ptr[IDX_W-1:0]] : 8'h00;
   assign off_step = off_in ? off + PTR_ONE    : off;
   assign wr_step  = wr_in  ? wr_ptr + PTR_ONE : wr_ptr;
   assign rd_step  = rd_in  ? rd_ptr + PTR_ONE : rd_ptr;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         st        <= S_IDLE;
         nxt       <= S_IDLE;
         bcnt      <= '0;
         sh        <= '0;
         tx        <= '0;
         sda_oe    <= 1'b0;
         ack_lo    <= 1'b0;
         more      <= 1'b0;
         mode_byte <= 1'b1;
         off       <= '0;
         wr_ptr    <= '0;
         rd_ptr    <= '0;
         wcnt      <= '0;
         we        <= 1'b0;
         waddr     <= '0;
         wdata     <= '0;
      end else begin
         we <= 1'b0;
         if (ev_start) begin
            st     <= S_ADDR;
            bcnt   <= '0;
            sda_oe <= 1'b0;
            ack_lo <= 1'b0;
         end else if (ev_stop) begin
            st     <= S_IDLE;
            sda_oe <= 1'b0;
            ack_lo <= 1'b0;
         end else if (ev_rise) begin
            case (st)
               S_ADDR, S_CMD, S_CNT, S_WDATA: begin
                  sh   <= rx_byte[6:0];
                  bcnt <= bcnt + 4'd1;
                  if (bcnt == 4'd7) begin
                     bcnt <= '0;
                     st   <= S_ACK;
                     case (st)
                        S_ADDR: begin
                           if (rx_byte[7:1] != DEV_ADDR) st  <= S_IGNORE;
                           else if (rx_byte[0])          nxt <= S_RDATA;
                           else                          nxt <= S_CMD;
                        end
                        S_CMD: begin
                           if (rx_byte[6:5] != 2'b00 ||
                               (!rx_byte[7] && rx_byte[4:0] != 5'd0)) begin
                              st <= S_IGNORE;
                           end else begin
                              mode_byte <= rx_byte[7];
                              off       <= rx_byte[4:0];
                              wr_ptr    <= rx_byte[7] ? rx_byte[4:0] : '0;
                              nxt       <= rx_byte[7] ? S_WDATA : S_CNT;
                           end
                        end
                        S_CNT: begin
                           wcnt <= rx_byte;
                           nxt  <= S_WDATA;
                        end
                        default: begin
                           if (!mode_byte && wcnt == 8'd0) begin
                              st <= S_IGNORE;
                           end else begin
                              if (wr_in) begin
                                 we    <= 1'b1;
                                 waddr <= wr_ptr[IDX_W-1:0];
                                 wdata <= rx_byte;
                              end
                              if (mode_byte) begin
                                 nxt <= S_IGNORE;
                              end else begin
                                 nxt    <= S_WDATA;
                                 wcnt   <= wcnt - 8'd1;
                                 wr_ptr <= wr_step;
                              end
                           end
                        end
                     endcase
                  end
               end
               S_RDATA: bcnt <= bcnt + 4'd1;
               S_RACK:  more <= ~sda_f;
               default: ;
            endcase
         end else if (ev_fall) begin
            case (st)
               S_ACK: begin
                  if (!ack_lo) begin
                     sda_oe <= 1'b1;
                     ack_lo <= 1'b1;
                  end else begin
                     ack_lo <= 1'b0;
                     st     <= nxt;
                     if (nxt == S_RDATA) begin
                        if (mode_byte) begin
                           tx     <= off_val;
                           sda_oe <= ~off_val[7];
                           rd_ptr <= off_step;
                        end else begin
                           tx     <= BLK_CNT;
                           sda_oe <= ~BLK_CNT[7];
                           rd_ptr <= '0;
                        end
                     end else begin
                        sda_oe <= 1'b0;
                     end
                  end
               end
               S_RDATA: begin
                  if (bcnt == 4'd8) begin
                     sda_oe <= 1'b0;
                     bcnt   <= '0;
                     st     <= S_RACK;
                  end else begin
                     tx     <= {tx[6:0], 1'b0};
                     sda_oe <= ~tx[6];
                  end
               end
               S_RACK: begin
                  if (more) begin
                     tx     <= rd_val;
                     sda_oe <= ~rd_val[7];
                     rd_ptr <= rd_step;
                     st     <= S_RDATA;
                  end else begin
                     st <= S_IGNORE;
                  end
               end
               default: ;
            endcase
         end
      end
   end

   // R9: the slave never moves SDA while the filtered clock is high.
   p_sda_moves_low_r9: assert property (@(posedge clk) disable iff (!rst_n)
      !$stable(sda_oe) |-> !scl_f);

   // R2: idle or ignoring means the line is left alone.
   p_quiet_when_ignoring_r2: assert property (@(posedge clk) disable iff (!rst_n)
      (st == S_IDLE || st == S_IGNORE) |-> !sda_oe);

   // R9: bit framing never runs past eight data bits.
   p_bit_count_bound_r9: assert property (@(posedge clk) disable iff (!rst_n)
      bcnt <= 4'd8);

endmodule

// File: tb/smb_cfg_slave_bench.sv
`timescale 1ns/1ps
module smb_cfg_slave_bench;
   localparam int Q = 16;

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        m_scl = 1'b1;
   logic        m_sda = 1'b1;
   logic        sda_oe;
   logic [63:0] cfg_q;
   logic        sda_bus;
   logic        glitch_en = 1'b0;

   int n_tests = 0;
   int n_fail  = 0;
   int oe_viol = 0;
   logic prev_oe = 1'b0;

   logic [7:0] dflt [8];

   assign sda_bus = m_sda & ~sda_oe;

   always #4 clk = ~clk;

   smb_cfg_slave u_smb_cfg_slave (
      .clk(clk), .rst_n(rst_n), .scl_i(m_scl), .sda_i(sda_bus),
      .sda_oe(sda_oe), .cfg_q(cfg_q));

   // R9 monitor: the slave enable must not move while SCL is high
   always @(negedge clk) begin
      if (rst_n && m_scl && (sda_oe != prev_oe)) oe_viol++;
      prev_oe <= sda_oe;
   end

   task automatic chk8(input string tag, input logic [7:0] act, input logic [7:0] exp);
      n_tests++;
      if (act !== exp) begin
         n_fail++;
         $display("FAIL %s actual=%02h expected=%02h", tag, act, exp);
      end
   endtask

   task automatic wq(input int n);
      repeat (n * Q) @(negedge clk);
   endtask

   task automatic bus_start();
      m_sda = 1'b1; m_scl = 1'b1; wq(1);
      m_sda = 1'b0; wq(1);
      m_scl = 1'b0; wq(1);
   endtask

   task automatic bus_rstart();
      m_sda = 1'b1; wq(1);
      m_scl = 1'b1; wq(1);
      m_sda = 1'b0; wq(1);
      m_scl = 1'b0; wq(1);
   endtask

   task automatic bus_stop();
      m_sda = 1'b0; wq(1);
      m_scl = 1'b1; wq(1);
      m_sda = 1'b1; wq(2);
   endtask

   task automatic wbyte(input logic [7:0] b, output logic ack);
      for (int i = 7; i >= 0; i--) begin
         m_sda = b[i]; wq(1);
         m_scl = 1'b1;
         if (glitch_en && i == 7 && b[i]) begin
            repeat (4) @(negedge clk);
            m_sda = 1'b0;
            repeat (2) @(negedge clk);
            m_sda = 1'b1;
            repeat (2 * Q - 6) @(negedge clk);
         end else begin
            wq(2);
         end
         m_scl = 1'b0; wq(1);
      end
      m_sda = 1'b1; wq(1);
      m_scl = 1'b1; wq(1);
      ack = ~sda_bus;
      wq(1);
      m_scl = 1'b0; wq(1);
   endtask

   task automatic rbyte(input logic give_ack, output logic [7:0] b);
      for (int i = 7; i >= 0; i--) begin
         m_sda = 1'b1; wq(1);
         m_scl = 1'b1; wq(1);
         b[i] = sda_bus;
         wq(1);
         m_scl = 1'b0; wq(1);
      end
      m_sda = ~give_ack; wq(1);
      m_scl = 1'b1; wq(2);
      m_scl = 1'b0; wq(1);
      m_sda = 1'b1;
   endtask

   task automatic read_one(input logic [7:0] cmd, output logic [7:0] v);
      logic a;
      bus_start();
      wbyte(8'hD2, a);
      wbyte(cmd, a);
      bus_rstart();
      wbyte(8'hD3, a);
      rbyte(1'b0, v);
      bus_stop();
   endtask

   task automatic t_reset();
      chk8("R1 sda released after reset", {7'd0, sda_oe}, 8'h00);
      for (int i = 0; i < 8; i++)
         chk8($sformatf("R1 default offset %0d", i), cfg_q[i*8 +: 8], dflt[i]);
   endtask

   task automatic t_byte_write();
      logic a;
      bus_start();
      wbyte(8'hD2, a); chk8("R2 write address ack", {7'd0, a}, 8'h01);
      wbyte(8'h82, a); chk8("R3 byte command ack", {7'd0, a}, 8'h01);
      wbyte(8'h5A, a); chk8("R4 data ack", {7'd0, a}, 8'h01);
      wbyte(8'h77, a); chk8("R4 second data byte nack", {7'd0, a}, 8'h00);
      bus_stop();
      chk8("R4 offset 2 written", cfg_q[23:16], 8'h5A);
      chk8("R4 offset 3 untouched", cfg_q[31:24], 8'hAF);
   endtask

   task automatic t_byte_read();
      logic [7:0] v;
      read_one(8'h82, v); chk8("R7 R9 read offset 2 msb first", v, 8'h5A);
      read_one(8'h86, v); chk8("R7 read offset 6", v, 8'h13);
      read_one(8'h87, v); chk8("R7 read offset 7", v, 8'h38);
      read_one(8'h89, v); chk8("R7 read offset 9 gives zero", v, 8'h00);
   endtask

   task automatic t_rejects();
      logic a;
      bus_start();
      wbyte(8'hA4, a); chk8("R2 foreign address nack", {7'd0, a}, 8'h00);
      wbyte(8'h82, a); chk8("R2 ignored command", {7'd0, a}, 8'h00);
      wbyte(8'h00, a); chk8("R2 ignored data", {7'd0, a}, 8'h00);
      bus_stop();
      chk8("R2 offset 2 kept", cfg_q[23:16], 8'h5A);
      bus_start();
      wbyte(8'hD2, a);
      wbyte(8'hA2, a); chk8("R3 chip select 01 nack", {7'd0, a}, 8'h00);
      wbyte(8'h00, a); chk8("R3 data after bad command nack", {7'd0, a}, 8'h00);
      bus_stop();
      chk8("R3 offset 2 kept", cfg_q[23:16], 8'h5A);
      bus_start();
      wbyte(8'hD2, a);
      wbyte(8'h03, a); chk8("R3 block offset nonzero nack", {7'd0, a}, 8'h00);
      bus_stop();
   endtask

   task automatic t_block_write();
      logic a;
      bus_start();
      wbyte(8'hD2, a);
      wbyte(8'h00, a); chk8("R3 block command ack", {7'd0, a}, 8'h01);
      wbyte(8'h0A, a); chk8("R5 count ack", {7'd0, a}, 8'h01);
      for (int i = 0; i < 10; i++) begin
         wbyte(8'h11 + 8'(i), a);
         chk8($sformatf("R5 data %0d ack", i), {7'd0, a}, 8'h01);
      end
      wbyte(8'h1B, a); chk8("R5 byte past count nack", {7'd0, a}, 8'h00);
      bus_stop();
      for (int i = 0; i < 7; i++)
         chk8($sformatf("R5 offset %0d filled", i), cfg_q[i*8 +: 8], 8'h11 + 8'(i));
      chk8("R6 offset 7 read-only", cfg_q[63:56], 8'h38);
   endtask

   task automatic t_block_read();
      logic a;
      logic [7:0] v;
      bus_start();
      wbyte(8'hD2, a);
      wbyte(8'h00, a);
      bus_rstart();
      wbyte(8'hD3, a); chk8("R2 read address ack", {7'd0, a}, 8'h01);
      rbyte(1'b1, v); chk8("R8 count byte", v, 8'h08);
      for (int i = 0; i < 7; i++) begin
         rbyte(1'b1, v);
         chk8($sformatf("R8 offset %0d", i), v, 8'h11 + 8'(i));
      end
      rbyte(1'b1, v); chk8("R8 offset 7", v, 8'h38);
      rbyte(1'b0, v); chk8("R8 past end gives zero", v, 8'h00);
      bus_stop();
   endtask

   task automatic t_stop_mid();
      logic a;
      logic [7:0] v;
      bus_start();
      wbyte(8'hD2, a);
      wbyte(8'h00, a);
      wbyte(8'h04, a);
      wbyte(8'hA1, a);
      wbyte(8'hA2, a);
      bus_stop();
      chk8("R10 offset 0 kept", cfg_q[7:0], 8'hA1);
      chk8("R10 offset 1 kept", cfg_q[15:8], 8'hA2);
      chk8("R10 offset 2 not reached", cfg_q[23:16], 8'h13);
      read_one(8'h81, v); chk8("R10 new transaction read", v, 8'hA2);
   endtask

   task automatic t_glitch();
      logic a;
      bus_start();
      wbyte(8'hD2, a);
      wbyte(8'h83, a);
      glitch_en = 1'b1;
      wbyte(8'hC3, a);
      glitch_en = 1'b0;
      chk8("R11 glitched byte ack", {7'd0, a}, 8'h01);
      bus_stop();
      chk8("R11 glitched byte stored", cfg_q[31:24], 8'hC3);
   endtask

   initial begin
      repeat (200000) @(posedge clk);
      n_fail++;
      $display("FAIL watchdog expired actual=%0d expected=%0d", n_tests, n_tests);
      $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
      $finish;
   end

   initial begin
      dflt[0] = 8'h7C; dflt[1] = 8'h00; dflt[2] = 8'hEB; dflt[3] = 8'hAF;
      dflt[4] = 8'h01; dflt[5] = 8'h00; dflt[6] = 8'h13; dflt[7] = 8'h38;
      repeat (5) @(negedge clk);
      rst_n = 1'b1;
      repeat (10) @(negedge clk);
      t_reset();
      t_byte_write();
      t_byte_read();
      t_rejects();
      t_block_write();
      t_block_read();
      t_stop_mid();
      t_glitch();
      chk8("R9 enable moved while SCL high", 8'(oe_viol), 8'h00);
      $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
      $finish;
   end

endmodule